// File: doc/BRIEF.md
# Triggered Acquisition Sequencer

This block decides, clock by clock, when a digitizer writes a sample into acquisition memory and at which address. A programmable divider turns the timebase clock into a sample cadence of one sample every `interval` clocks. Four placement modes decide which samples around a trigger event are kept. Post mode keeps a block of samples after the trigger. Delay mode does the same after a programmed number of idle clocks. Pre mode keeps only the newest samples before the trigger, written round a circular region. Middle mode keeps a circular pre-trigger region and then a linear post-trigger region.

In post and delay modes, the retrigger option captures one fixed-size block for each accepted trigger, and the blocks are stored back to back. A one-cycle done pulse closes every acquisition. All configuration inputs are expected to stay stable from the start command to the done pulse. The memory and the transfer of data out of it lie outside this block.

Top module: `acq_sequencer`

## Requirements
- R1: After reset `sample_en`, `busy` and `done` are low and `wr_addr` is 0.
- R2: While capturing, `sample_en` is high on the first capture cycle and then on every `interval`-th clock. An interval of 0 or 1 samples on every clock.
- R3: Post mode (`mode` = 0): a trigger sampled at clock edge e gives strobes in the cycles e, e+interval, and so on. There are exactly `data_count` strobes, at addresses 0, 1, 2 and upward.
- R4: `done` is high for exactly one cycle, and `busy` is low in that cycle. For post-style captures, `done` comes in the cycle after the last strobe. For pre and middle captures with no post part, it comes in the cycle after the accepted trigger edge.
- R5: Delay mode (`mode` = 3): every strobe comes `delay_ticks` cycles later than it would in post mode.
- R6: With `retrig_en` = 1 in post or delay mode, `trig_total` blocks are captured, one per accepted trigger. Block j uses addresses j*`data_count` and up, and no `done` appears between blocks. With `retrig_en` = 0 only one block is captured.
- R7: Triggers that arrive during an active block or during the delay wait are ignored.
- R8: Pre mode (`mode` = 1): strobes start in the cycle after the start edge and run on the cadence until an accepted trigger. Addresses run modulo `data_count`.
- R9: In pre and middle modes, a trigger is accepted only when at least the ring length has been written by that edge (`data_count` for pre, `pre_count` for middle). Earlier triggers are ignored.
- R10: Middle mode (`mode` = 2): the pre part writes round addresses modulo `pre_count`. After the accepted trigger, `post_count` further strobes follow on the unbroken cadence at addresses `pre_count`, `pre_count`+1 and up. A `post_count` of 0 ends the capture at the trigger.
- R11: `start` has no effect while `busy`, and `trig` has no effect while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Arms an acquisition when idle |
| trig | input | 1 | Trigger event, sampled each edge |
| mode | input | 2 | 0 post, 1 pre, 2 middle, 3 delay |
| retrig_en | input | 1 | Multi-block capture in post or delay mode |
| interval | input | INTV_W | Clocks per sample |
| data_count | input | CNT_W | Block size (post, delay) or ring length (pre) |
| pre_count | input | CNT_W | Middle-mode ring length |
| post_count | input | CNT_W | Middle-mode samples after trigger |
| delay_ticks | input | DLY_W | Delay-mode wait in clocks |
| trig_total | input | TRG_W | Number of blocks when retriggering |
| sample_en | output | 1 | Write strobe for the current sample |
| wr_addr | output | ADDR_W | Write address of the current sample |
| busy | output | 1 | Acquisition in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Every output is a register, so nothing responds in the same cycle as its stimulus. A trigger or start seen at edge e affects the outputs in cycle e and no earlier. From there, strobes follow on the interval cadence. In delay mode they are shifted by the delay count. The done pulse lands one cycle after the last write edge. The bench numbers every cycle by the edges it has seen, drives inputs and logs outputs on the falling edge, and records each strobe with its cycle number and address. It then compares that log against cycle and address lists computed in closed form from the start edge, trigger edges, interval and counts. This covers the cases of ignored early and mid-block triggers.

// File: rtl/acq_sequencer.sv
module acq_sequencer #(
  parameter int INTV_W = 24,
  parameter int CNT_W  = 16,
  parameter int DLY_W  = 16,
  parameter int TRG_W  = 8,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              trig,
  input  logic [1:0]        mode,
  input  logic              retrig_en,
  input  logic [INTV_W-1:0] interval,
  input  logic [CNT_W-1:0]  data_count,
  input  logic [CNT_W-1:0]  pre_count,
  input  logic [CNT_W-1:0]  post_count,
  input  logic [DLY_W-1:0]  delay_ticks,
  input  logic [TRG_W-1:0]  trig_total,
  output logic              sample_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              busy,
  output logic              done
);

  localparam logic [1:0] M_POST = 2'd0;
  localparam logic [1:0] M_PRE  = 2'd1;
  localparam logic [1:0] M_MID  = 2'd2;
  localparam logic [1:0] M_DLY  = 2'd3;
  localparam int PW = ((ADDR_W > CNT_W) ? ADDR_W : CNT_W) + 1;

  typedef enum logic [2:0] {S_IDLE, S_ARM, S_WAIT, S_SEG, S_RING, S_TAIL} state_t;

  state_t            st;
  logic [INTV_W-1:0] div;
  logic [CNT_W-1:0]  n_smp;
  logic [CNT_W-1:0]  fill;
  logic [DLY_W-1:0]  dly;
  logic [TRG_W-1:0]  segs;
  logic [ADDR_W-1:0] addr;

  wire              capturing = (st == S_SEG) || (st == S_RING) || (st == S_TAIL);
  wire [INTV_W:0]   div_inc   = {1'b0, div} + (INTV_W+1)'(1);
  wire              div_wrap  = div_inc >= {1'b0, interval};
  wire [CNT_W:0]    n_inc     = {1'b0, n_smp} + (CNT_W+1)'(1);
  wire [CNT_W:0]    fill_inc  = {1'b0, fill} + (CNT_W+1)'(1);
  wire [CNT_W-1:0]  ring_len  = (mode == M_PRE) ? data_count : pre_count;
  wire              fill_sat  = {1'b0, fill} >= {1'b0, ring_len};
  wire              ring_full = fill_sat || (sample_en && fill_inc >= {1'b0, ring_len});
  wire              seg_last  = n_inc >= {1'b0, data_count};
  wire              tail_last = n_inc >= {1'b0, post_count};
  wire [TRG_W-1:0]  seg_goal  = (retrig_en && trig_total != '0) ? trig_total : TRG_W'(1);
  wire              more_segs = ({1'b0, segs} + (TRG_W+1)'(1)) < {1'b0, seg_goal};
  wire [ADDR_W-1:0] addr_inc  = addr + ADDR_W'(1);
  wire [ADDR_W-1:0] ring_next = ((PW'(addr) + PW'(1)) >= PW'(ring_len)) ? '0 : addr_inc;

  assign sample_en = capturing && (div == '0);
  assign wr_addr   = addr;
  assign busy      = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      div   <= '0;
      n_smp <= '0;
      fill  <= '0;
      dly   <= '0;
      segs  <= '0;
      addr  <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      div  <= (capturing && !div_wrap) ? div_inc[INTV_W-1:0] : '0;
      case (st)
        S_IDLE: if (start) begin
          addr  <= '0;
          segs  <= '0;
          n_smp <= '0;
          fill  <= '0;
          st    <= (mode == M_PRE || mode == M_MID) ? S_RING : S_ARM;
        end
        S_ARM: if (trig) begin
          n_smp <= '0;
          if (mode == M_DLY && delay_ticks != '0) begin
            dly <= delay_ticks - DLY_W'(1);
            st  <= S_WAIT;
          end else begin
            st <= S_SEG;
          end
        end
        S_WAIT: begin
          if (dly == '0) st <= S_SEG;
          else dly <= dly - DLY_W'(1);
        end
        S_SEG: if (sample_en) begin
          addr  <= addr_inc;
          n_smp <= n_inc[CNT_W-1:0];
          if (seg_last) begin
            n_smp <= '0;
            if (more_segs) begin
              segs <= segs + TRG_W'(1);
              st   <= S_ARM;
            end else begin
              st   <= S_IDLE;
              done <= 1'b1;
            end
          end
        end
        S_RING: begin
          if (sample_en) begin
            addr <= ring_next;
            if (!fill_sat) fill <= fill_inc[CNT_W-1:0];
          end
          if (trig && ring_full) begin
            if (mode == M_MID && post_count != '0) begin
              st    <= S_TAIL;
              addr  <= ADDR_W'(pre_count);
              n_smp <= '0;
            end else begin
              st   <= S_IDLE;
              done <= 1'b1;
            end
          end
        end
        S_TAIL: if (sample_en) begin
          addr  <= addr_inc;
          n_smp <= n_inc[CNT_W-1:0];
          if (tail_last) begin
            st   <= S_IDLE;
            done <= 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_strobe_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_en && interval > INTV_W'(1)) |=> !sample_en);

  assert_seg_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SEG && sample_en) |=> (wr_addr == $past(wr_addr) + ADDR_W'(1)));

  assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_ring_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RING && ring_len != '0) |-> (PW'(wr_addr) < PW'(ring_len)));

endmodule

// File: tb/acq_sequencer_test.sv
`timescale 1ns/1ps
module acq_sequencer_test;
  logic        clk = 0, rst_n = 0, start = 0, trig = 0, retrig_en = 0;
  logic [1:0]  mode = 0;
  logic [23:0] interval = 1;
  logic [15:0] data_count = 1, pre_count = 1, post_count = 1, delay_ticks = 0;
  logic [7:0]  trig_total = 1;
  wire         sample_en, busy, done;
  wire  [15:0] wr_addr;

  acq_sequencer uut (
    .clk(clk), .rst_n(rst_n), .start(start), .trig(trig), .mode(mode),
    .retrig_en(retrig_en), .interval(interval), .data_count(data_count),
    .pre_count(pre_count), .post_count(post_count), .delay_ticks(delay_ticks),
    .trig_total(trig_total), .sample_en(sample_en), .wr_addr(wr_addr),
    .busy(busy), .done(done));

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, errors = 0;
  int sc [0:255];
  int sa [0:255];
  int ec [0:255];
  int ea [0:255];
  int n = 0, dn = 0, dcyc = -1, dbusy = 0, en = 0, edc = 0;

  always @(negedge clk) if (rst_n) begin
    if (sample_en) begin
      if (n < 256) begin sc[n] = cyc; sa[n] = int'(wr_addr); end
      n++;
    end
    if (done) begin dn++; dcyc = cyc; dbusy = int'(busy); end
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clear();
    n = 0; dn = 0; dcyc = -1; dbusy = 0;
  endtask

  task automatic pulse(int e, bit s, bit t);
    while (cyc < e - 1) @(negedge clk);
    start = s; trig = t;
    @(negedge clk);
    start = 0; trig = 0;
  endtask

  task automatic finish_run();
    for (int i = 0; i < 600 && dn == 0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic verify(string req);
    int bad;
    bad = -1;
    check(n == en, req, "strobe count", n, en);
    for (int i = 0; i < en && i < n && i < 256; i++)
      if (bad < 0 && (sc[i] != ec[i] || sa[i] != ea[i])) bad = i;
    if (bad >= 0) begin
      check(sc[bad] == ec[bad], req, $sformatf("strobe %0d cycle", bad), sc[bad], ec[bad]);
      check(sa[bad] == ea[bad], req, $sformatf("strobe %0d addr", bad), sa[bad], ea[bad]);
    end else check(1'b1, req, "strobes", 0, 0);
    check(dn == 1, "R4", "done pulses", dn, 1);
    check(dcyc == edc, "R4", "done cycle", dcyc, edc);
    check(dbusy == 0, "R4", "busy at done", dbusy, 0);
  endtask

  task automatic ring_run(logic [1:0] md, int k, int m, int nn, int extra, string req);
    int s, t, t0, p;
    mode = md; interval = 24'(k);
    if (md == 2'd1) begin data_count = 16'(m); post_count = 3; end
    else begin pre_count = 16'(m); post_count = 16'(nn); data_count = 7; end
    clear();
    s = cyc + 2;
    pulse(s, 1, 0);
    t0 = s + (m - 2) * k + 1;
    pulse(s + 1, 1, (m >= 2 && t0 == s + 1));
    if (m >= 2 && t0 > s + 1) pulse(t0, 0, 1);
    t = s + m * k + 1 + extra;
    pulse(t, 0, 1);
    finish_run();
    p = (t - s + k - 1) / k;
    en = p + nn;
    for (int i = 0; i < en; i++) begin
      ec[i] = s + i * k;
      ea[i] = (i < p) ? (i % m) : (m + i - p);
    end
    edc = (nn > 0) ? s + (p + nn - 1) * k + 1 : t;
    verify(req);
  endtask

  initial begin
    #(4 * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int s, e, e1, e2;
    repeat (3) @(negedge clk);
    check(sample_en == 0 && busy == 0 && done == 0, "R1", "control outputs", int'({sample_en, busy, done}), 0);
    check(wr_addr == 0, "R1", "wr_addr", int'(wr_addr), 0);
    rst_n = 1;
    @(negedge clk);

    clear();
    pulse(cyc + 1, 0, 1);
    repeat (5) @(negedge clk);
    check(n == 0 && busy == 0, "R11", "trigger while idle", n + int'(busy), 0);

    // R3, R2, R7, R11: post mode sweep
    mode = 0; retrig_en = 0;
    for (int k = 1; k <= 3; k++)
      for (int c = 1; c <= 4; c++) begin
        interval = 24'(k); data_count = 16'(c);
        clear();
        s = cyc + 2;
        pulse(s, 1, 0);
        e = s + 2;
        pulse(e, 0, 1);
        if (c >= 2) pulse(e + 1, 1, 1);
        finish_run();
        en = c;
        for (int i = 0; i < c; i++) begin ec[i] = e + i * k; ea[i] = i; end
        edc = e + (c - 1) * k + 1;
        verify(k > 1 ? "R2" : "R3");
      end

    // R5, R7: delay mode
    mode = 3; data_count = 2;
    for (int k = 1; k <= 2; k++)
      for (int d = 0; d <= 3; d++) begin
        interval = 24'(k); delay_ticks = 16'(d);
        clear();
        s = cyc + 2;
        pulse(s, 1, 0);
        e = s + 2;
        pulse(e, 0, 1);
        if (d >= 1) pulse(e + 1, 0, 1);
        finish_run();
        en = 2;
        for (int i = 0; i < 2; i++) begin ec[i] = e + d + i * k; ea[i] = i; end
        edc = e + d + k + 1;
        verify("R5");
      end

    // R6: post-mode retrigger, three blocks
    mode = 0; interval = 1; data_count = 2; retrig_en = 1; trig_total = 3;
    clear();
    s = cyc + 2;
    pulse(s, 1, 0);
    e = s + 2; e1 = e + 5; e2 = e1 + 5;
    pulse(e, 0, 1);
    pulse(e + 1, 0, 1);
    pulse(e1, 0, 1);
    check(dn == 0 && busy == 1, "R6", "no done between blocks", dn, 0);
    pulse(e2, 0, 1);
    finish_run();
    en = 6;
    for (int i = 0; i < 2; i++) begin
      ec[i] = e + i; ec[2 + i] = e1 + i; ec[4 + i] = e2 + i;
      ea[i] = i; ea[2 + i] = 2 + i; ea[4 + i] = 4 + i;
    end
    edc = e2 + 2;
    verify("R6");

    // R6: delay-mode retrigger, two blocks
    mode = 3; delay_ticks = 2; trig_total = 2;
    clear();
    s = cyc + 2;
    pulse(s, 1, 0);
    e = s + 2; e1 = e + 7;
    pulse(e, 0, 1);
    pulse(e1, 0, 1);
    finish_run();
    en = 4;
    for (int i = 0; i < 2; i++) begin
      ec[i] = e + 2 + i; ec[2 + i] = e1 + 2 + i;
      ea[i] = i; ea[2 + i] = 2 + i;
    end
    edc = e1 + 4;
    verify("R6");

    // R6: retrigger disabled keeps a single block
    mode = 0; retrig_en = 0; trig_total = 3;
    clear();
    s = cyc + 2;
    pulse(s, 1, 0);
    e = s + 2;
    pulse(e, 0, 1);
    pulse(e + 6, 0, 1);
    finish_run();
    en = 2;
    for (int i = 0; i < 2; i++) begin ec[i] = e + i; ea[i] = i; end
    edc = e + 2;
    verify("R6");

    // R8, R9: pre mode
    for (int k = 1; k <= 2; k++)
      for (int m = 1; m <= 4; m++)
        ring_run(2'd1, k, m, 0, (m + k) % 3, m >= 2 ? "R9" : "R8");

    // R10: middle mode
    for (int m = 1; m <= 3; m++)
      for (int nn = 0; nn <= 3; nn++)
        ring_run(2'd2, 1, m, nn, nn % 2, "R10");
    ring_run(2'd2, 2, 2, 2, 0, "R10");
    ring_run(2'd2, 3, 3, 2, 1, "R10");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule